// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block decides where a single-cycle processor core fetches next. In one combinational pass it takes the address of the current instruction, the instruction word, and the two operand values already read from the register file. From these it produces the following fetch address, a flag that says control flow was redirected, and the return address that a call instruction stores.

The unit covers four kinds of instruction. Sequential instructions step to the next word. Region jumps replace the low 28 bits of the incremented address with a 26-bit word index. The register jump takes its destination from an operand. Conditional branches test two operands for equality, or test one operand's sign against zero, and then add a scaled signed word offset to the incremented address.

The core latches the next-address output into its program counter. It uses the link enable and link value to write the return register, which is fixed at index 31 by the core. Register-file writes, delay-slot execution and exceptions are handled outside the block.

Top module: `npc_unit`

## Requirements
- R1: Any instruction that is not a jump or branch, including opcode 0x00 with a function code other than 0x08, gives next PC = PC+4, the taken flag low and the link enable low.
- R2: Opcode 0x02 (instruction bits 31..26) gives next PC = {bits 31..28 of PC+4, instruction bits 25..0, 2'b00}, with the taken flag high.
- R3: Opcode 0x03 jumps to the same target as R2 and raises the link enable. The link value always equals PC+8, modulo 2^32.
- R4: Opcode 0x00 with function code 0x08 (bits 5..0) gives next PC = the rs operand value, with the taken flag high.
- R5: Opcode 0x04 is taken when the rs and rt operands are equal. The taken target is PC+4 plus the sign-extended 16-bit offset (bits 15..0) shifted left by two. When not taken, next PC = PC+4.
- R6: Opcode 0x05 uses the same target as R5 and is taken when the rs and rt operands differ.
- R7: Opcode 0x01 reads bits 20..16 as a sub-opcode. Value 0 is taken when rs < 0 (signed), value 1 is taken when rs ≥ 0, and any other value is not taken (next PC = PC+4).
- R8: Opcode 0x06 is taken when rs ≤ 0 (signed), and opcode 0x07 is taken when rs > 0 (signed). Both use the R5 target.
- R9: Jump targets keep the top four bits of PC+4. When PC+4 crosses into a new 256 MB region, the target lies in that new region.
- R10: The taken flag is high exactly for jumps and for branches whose condition holds. The link enable is high only for opcode 0x03.
- R11: All address sums wrap modulo 2^32, both for negative branch offsets below address zero and for PC+4 past the top of the address space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value read for the rs register field |
| rt_val_i | input | 32 | Value read for the rt register field |
| next_pc_o | output | 32 | Address of the next instruction |
| taken_o | output | 1 | Control flow redirected away from PC+4 |
| link_we_o | output | 1 | Write the link value to the return register |
| link_data_o | output | 32 | Return address, PC+8 |

## Verification
The bench builds the unit at its default values: a 32-bit address width, the plain equality comparator, and the branch adder that folds the +4 into the offset first. At 32 bits the region field is exactly four bits wide. This lets the bench test a jump issued from the last word of a region, and branches whose sums wrap around below zero and past the top of the address space. The folded adder variant puts the wrapped negative-offset case and the most-negative offset in the path that the bench exercises.

// File: rtl/npc_pkg.sv
package npc_pkg;

   localparam int unsigned INSN_W = 32;
   localparam int unsigned OPC_W  = 6;

   localparam logic [5:0] OPC_SPECIAL = 6'h00;
   localparam logic [5:0] OPC_REGIMM  = 6'h01;
   localparam logic [5:0] OPC_JUMP    = 6'h02;
   localparam logic [5:0] OPC_CALL    = 6'h03;
   localparam logic [5:0] OPC_EQ      = 6'h04;
   localparam logic [5:0] OPC_NE      = 6'h05;
   localparam logic [5:0] OPC_LEZ     = 6'h06;
   localparam logic [5:0] OPC_GTZ     = 6'h07;
   localparam logic [5:0] FN_REGJMP   = 6'h08;

   typedef enum logic [3:0] {
      FLOW_SEQ,
      FLOW_JUMP,
      FLOW_CALL,
      FLOW_REGJMP,
      FLOW_EQ,
      FLOW_NE,
      FLOW_LTZ,
      FLOW_GEZ,
      FLOW_LEZ,
      FLOW_GTZ
   } flow_e;

   function automatic logic is_branch(input flow_e k);
      return (k == FLOW_EQ) || (k == FLOW_NE) || (k == FLOW_LTZ) ||
             (k == FLOW_GEZ) || (k == FLOW_LEZ) || (k == FLOW_GTZ);
   endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic [5:0] opc_i,
   input  logic [4:0] sub_i,
   input  logic [5:0] fn_i,
   output flow_e      kind_o
);

   always_comb begin
      kind_o = FLOW_SEQ;
      unique case (opc_i)
         OPC_SPECIAL: kind_o = (fn_i == FN_REGJMP) ? FLOW_REGJMP : FLOW_SEQ;
         OPC_REGIMM: begin
            if (sub_i == 5'd0)      kind_o = FLOW_LTZ;
            else if (sub_i == 5'd1) kind_o = FLOW_GEZ;
            else                    kind_o = FLOW_SEQ;   // R7
         end
         OPC_JUMP: kind_o = FLOW_JUMP;
         OPC_CALL: kind_o = FLOW_CALL;
         OPC_EQ:   kind_o = FLOW_EQ;
         OPC_NE:   kind_o = FLOW_NE;
         OPC_LEZ:  kind_o = FLOW_LEZ;
         OPC_GTZ:  kind_o = FLOW_GTZ;
         default:  kind_o = FLOW_SEQ;
      endcase
   end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
   import npc_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned EQ_STYLE = 0
)(
   input  flow_e            kind_i,
   input  logic [XLEN-1:0]  a_i,
   input  logic [XLEN-1:0]  b_i,
   output logic             redirect_o
);

   logic same;
   logic neg;
   logic zero;

   if (EQ_STYLE > 1) begin : g_bad_eq
      $error("npc_cond: EQ_STYLE must be 0 or 1");
   end

   if (EQ_STYLE == 0) begin : g_eq_cmp
      assign same = (a_i == b_i);
   end else begin : g_eq_xor
      assign same = ~|(a_i ^ b_i);
   end

   assign neg  = a_i[XLEN-1];
   assign zero = (a_i == '0);

   always_comb begin
      unique case (kind_i)
         FLOW_JUMP, FLOW_CALL, FLOW_REGJMP: redirect_o = 1'b1;
         FLOW_EQ:  redirect_o = same;
         FLOW_NE:  redirect_o = ~same;
         FLOW_LTZ: redirect_o = neg;
         FLOW_GEZ: redirect_o = ~neg;
         FLOW_LEZ: redirect_o = neg | zero;
         FLOW_GTZ: redirect_o = ~neg & ~zero;
         default:  redirect_o = 1'b0;
      endcase
   end

   always_comb begin
      if (kind_i == FLOW_GTZ && redirect_o)
         AST_GTZ_POSITIVE: assert ($signed(a_i) > 0);          // R8
      if (kind_i == FLOW_LTZ && redirect_o)
         AST_LTZ_NEGATIVE: assert ($signed(a_i) < 0);          // R7
   end

endmodule

// File: rtl/npc_targets.sv
module npc_targets #(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned BR_PRE_ADD  = 1
)(
   input  logic [XLEN-1:0] pc_i,
   input  logic [15:0]     off_i,
   input  logic [25:0]     idx_i,
   output logic [XLEN-1:0] seq_o,
   output logic [XLEN-1:0] link_o,
   output logic [XLEN-1:0] br_o,
   output logic [XLEN-1:0] jmp_o
);

   localparam int unsigned REGION_LSB = 28;
   localparam int unsigned EXT_W      = XLEN - 18;
   localparam logic [XLEN-1:0] STEP   = XLEN'(4);

   logic [XLEN-1:0] off_sx;

   if (XLEN < 32) begin : g_bad_xlen
      $error("npc_targets: XLEN must be at least 32");
   end

   assign off_sx = {{EXT_W{off_i[15]}}, off_i, 2'b00};
   assign seq_o  = pc_i + STEP;
   assign link_o = pc_i + (STEP << 1);
   assign jmp_o  = {seq_o[XLEN-1:REGION_LSB], idx_i, 2'b00};

   if (BR_PRE_ADD != 0) begin : g_br_folded
      logic [XLEN-1:0] off_step;
      assign off_step = off_sx + STEP;
      assign br_o     = pc_i + off_step;
   end else begin : g_br_chained
      assign br_o = seq_o + off_sx;
   end

   always_comb begin
      AST_LINK_AHEAD: assert (link_o - seq_o == STEP);       // R3
      AST_JUMP_REGION: assert (jmp_o[XLEN-1:REGION_LSB] == seq_o[XLEN-1:REGION_LSB]); // R9
   end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned EQ_STYLE   = 0,
   parameter int unsigned BR_PRE_ADD = 1
)(
   input  logic [31:0] pc_i,
   input  logic [31:0] instr_i,
   input  logic [31:0] rs_val_i,
   input  logic [31:0] rt_val_i,
   output logic [31:0] next_pc_o,
   output logic        taken_o,
   output logic        link_we_o,
   output logic [31:0] link_data_o
);

   if (XLEN != INSN_W) begin : g_bad_top
      $error("npc_unit: port width is fixed at 32 bits");
   end

   flow_e            kind;
   logic             redirect;
   logic [XLEN-1:0]  seq_pc;
   logic [XLEN-1:0]  link_pc;
   logic [XLEN-1:0]  br_pc;
   logic [XLEN-1:0]  jmp_pc;

   npc_decode u_decode (
      .opc_i  (instr_i[31:26]),
      .sub_i  (instr_i[20:16]),
      .fn_i   (instr_i[5:0]),
      .kind_o (kind)
   );

   npc_cond #(.XLEN(XLEN), .EQ_STYLE(EQ_STYLE)) u_cond (
      .kind_i     (kind),
      .a_i        (rs_val_i),
      .b_i        (rt_val_i),
      .redirect_o (redirect)
   );

   npc_targets #(.XLEN(XLEN), .BR_PRE_ADD(BR_PRE_ADD)) u_targets (
      .pc_i   (pc_i),
      .off_i  (instr_i[15:0]),
      .idx_i  (instr_i[25:0]),
      .seq_o  (seq_pc),
      .link_o (link_pc),
      .br_o   (br_pc),
      .jmp_o  (jmp_pc)
   );

   always_comb begin
      next_pc_o = seq_pc;
      if (redirect) begin
         unique case (kind)
            FLOW_JUMP, FLOW_CALL: next_pc_o = jmp_pc;
            FLOW_REGJMP:          next_pc_o = rs_val_i;
            default:              next_pc_o = br_pc;
         endcase
      end
   end

   assign taken_o     = redirect;
   assign link_we_o   = (kind == FLOW_CALL);
   assign link_data_o = link_pc;

   always_comb begin
      if (!taken_o)
         AST_FALLTHROUGH: assert (next_pc_o == pc_i + 32'd4);   // R1
      if (link_we_o)
         AST_LINK_IMPLIES_TAKEN: assert (taken_o);              // R10
      if (taken_o && is_branch(kind))
         AST_BRANCH_ALIGN: assert (next_pc_o[1:0] == pc_i[1:0]); // R5
   end

endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;

   logic        clk = 1'b0;
   logic        done = 1'b0;
   int          n_vec = 0;
   int          n_bad = 0;

   logic [31:0] pc, ins, rsv, rtv;
   logic [31:0] nxt, lnk;
   logic        tkn, lwe;

   logic [65:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;   // 250 MHz

   npc_unit uut (
      .pc_i        (pc),
      .instr_i     (ins),
      .rs_val_i    (rsv),
      .rt_val_i    (rtv),
      .next_pc_o   (nxt),
      .taken_o     (tkn),
      .link_we_o   (lwe),
      .link_data_o (lnk)
   );

   function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] s,
                                         input logic [4:0] t, input logic [15:0] imm);
      return {op, s, t, imm};
   endfunction

   task automatic apply(input logic [31:0] p, input logic [31:0] i, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] e_next, input logic e_tkn,
                        input logic e_we, input string tag);
      @(posedge clk);
      #1;
      pc = p; ins = i; rsv = a; rtv = b;
      exp_q.push_back({e_next, e_tkn, e_we, p + 32'd8});
      tag_q.push_back(tag);
   endtask

   always @(negedge clk) begin
      if (exp_q.size() != 0) begin
         logic [65:0] e;
         string       t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_vec++;
         if ({nxt, tkn, lwe, lnk} !== e) begin
            n_bad++;
            $display("FAIL %s: got next=%h taken=%b we=%b link=%h, expected next=%h taken=%b we=%b link=%h",
                     t, nxt, tkn, lwe, lnk, e[65:34], e[33], e[32], e[31:0]);
         end
      end
   end

   initial begin
      pc = 32'd0; ins = 32'd0; rsv = 32'd0; rtv = 32'd0;
      // R1: plain arithmetic opcode, and opcode 0 with another function code
      apply(32'h0040_0000, itype(6'h08, 5'd1, 5'd2, 16'h0005), 32'd0, 32'd0, 32'h0040_0004, 0, 0, "R1 addi");
      apply(32'h0040_0004, {6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20}, 32'd7, 32'd9, 32'h0040_0008, 0, 0, "R1 fn20");
      // R2 region jump
      apply(32'h1000_0000, {6'h02, 26'h012_3456}, 32'd0, 32'd0, 32'h1048_D158, 1, 0, "R2 jump");
      // R3 and R10 call with link
      apply(32'h0040_0010, {6'h03, 26'h010_0000}, 32'd0, 32'd0, 32'h0040_0000, 1, 1, "R3 call");
      // R9 region taken from PC+4 across a region boundary
      apply(32'h2FFF_FFFC, {6'h02, 26'h000_0010}, 32'd0, 32'd0, 32'h3000_0040, 1, 0, "R9 cross");
      // R4 register jump
      apply(32'h0000_2000, {6'h00, 5'd3, 15'd0, 6'h08}, 32'hABCD_1234, 32'd0, 32'hABCD_1234, 1, 0, "R4 jr");
      // R5 equality
      apply(32'h0000_1000, itype(6'h04, 5'd5, 5'd1, 16'h0003), 32'h55, 32'h55, 32'h0000_1010, 1, 0, "R5 eq taken");
      apply(32'h0000_1000, itype(6'h04, 5'd5, 5'd1, 16'h0003), 32'h55, 32'h56, 32'h0000_1004, 0, 0, "R5 eq not");
      // R6 inequality
      apply(32'h0000_1000, itype(6'h05, 5'd5, 5'd1, 16'hFFFF), 32'h55, 32'h56, 32'h0000_1000, 1, 0, "R6 ne taken");
      apply(32'h0000_1000, itype(6'h05, 5'd5, 5'd1, 16'hFFFF), 32'h55, 32'h55, 32'h0000_1004, 0, 0, "R6 ne not");
      // R7 sub-opcode branches
      apply(32'h0000_1000, itype(6'h01, 5'd4, 5'd0, 16'h0002), 32'h8000_0000, 32'd0, 32'h0000_100C, 1, 0, "R7 ltz taken");
      apply(32'h0000_1000, itype(6'h01, 5'd4, 5'd0, 16'h0002), 32'd0, 32'd0, 32'h0000_1004, 0, 0, "R7 ltz zero");
      apply(32'h0000_1000, itype(6'h01, 5'd4, 5'd1, 16'h0002), 32'd0, 32'd0, 32'h0000_100C, 1, 0, "R7 gez zero");
      apply(32'h0000_1000, itype(6'h01, 5'd4, 5'd1, 16'h0002), 32'hFFFF_FFFF, 32'd0, 32'h0000_1004, 0, 0, "R7 gez neg");
      apply(32'h0000_1000, itype(6'h01, 5'd4, 5'd2, 16'h0002), 32'd0, 32'd0, 32'h0000_1004, 0, 0, "R7 sub2");
      apply(32'h0000_1000, itype(6'h01, 5'd4, 5'd17, 16'h0002), 32'h8000_0000, 32'd0, 32'h0000_1004, 0, 0, "R7 sub17");
      // R8 signed zero compares
      apply(32'h0000_1000, itype(6'h06, 5'd4, 5'd0, 16'h0001), 32'd0, 32'd0, 32'h0000_1008, 1, 0, "R8 lez zero");
      apply(32'h0000_1000, itype(6'h06, 5'd4, 5'd0, 16'h0001), 32'd1, 32'd0, 32'h0000_1004, 0, 0, "R8 lez one");
      apply(32'h0000_1000, itype(6'h07, 5'd4, 5'd0, 16'h0001), 32'd1, 32'd0, 32'h0000_1008, 1, 0, "R8 gtz one");
      apply(32'h0000_1000, itype(6'h07, 5'd4, 5'd0, 16'h0001), 32'h8000_0000, 32'd0, 32'h0000_1004, 0, 0, "R8 gtz min");
      apply(32'h0000_1000, itype(6'h07, 5'd4, 5'd0, 16'h0001), 32'h7FFF_FFFF, 32'd0, 32'h0000_1008, 1, 0, "R8 gtz max");
      apply(32'h0000_1000, itype(6'h07, 5'd4, 5'd0, 16'h0001), 32'd0, 32'd0, 32'h0000_1004, 0, 0, "R8 gtz zero");
      // R11 wrap-around
      apply(32'h0000_0000, itype(6'h04, 5'd1, 5'd1, 16'h8000), 32'd3, 32'd3, 32'hFFFE_0004, 1, 0, "R11 wrap low");
      apply(32'hFFFF_FFFC, itype(6'h04, 5'd1, 5'd1, 16'h0000), 32'd3, 32'd3, 32'h0000_0000, 1, 0, "R11 wrap high");
      apply(32'hFFFF_FFF8, itype(6'h08, 5'd1, 5'd1, 16'h0000), 32'd0, 32'd0, 32'hFFFF_FFFC, 0, 0, "R11 link wrap");
      // R10 call from a region edge still raises link
      apply(32'h0FFF_FFFC, {6'h03, 26'h3FF_FFFF}, 32'd0, 32'd0, 32'h1FFF_FFFC, 1, 1, "R10 call edge");
      repeat (3) @(posedge clk);
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R1: %0d results never observed, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1: watchdog expired, got hang, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule